// File: doc/BRIEF.md
# DVI Line Streamer and Serializer

This block turns per-pixel TMDS symbols into the eight single-ended bit streams of a minimal DVI link. It runs entirely on the bit-rate clock, which is ten times the pixel rate (250 MHz for a 25 MHz pixel rate). Every tenth bit clock it raises a load strobe and captures one 10-bit symbol for each colour channel. It then shifts each symbol out least significant bit first, with no idle bit between symbols. A fourth lane carries the link clock as a fixed pattern of five ones and then five zeros, so that its edges line up with the symbol boundaries. Each plus leg is driven next to its inverted minus leg.

The block also keeps the raster position. It has a pixel counter and a line counter, and it classifies every line as one of three kinds: a visible line, a plain blanking line, or a blanking line that carries vertical sync. The surrounding logic reads the kind and the pixel index in the cycle of the load strobe and presents the matching prebuilt symbols. The symbols themselves come from outside the block, and so does their encoding. The default geometry is 640x480 progressive at about 60 Hz. That is 800 pixel clocks per line and 525 lines per frame, made of 480 visible lines, 10 front-porch lines, 2 sync lines and 33 back-porch lines.

Top module: `dvi_line_serializer`

## Requirements
- R1: The output word maps its pairs as follows: bits 7/6 are red, bits 5/4 are green, bits 3/2 are blue and bits 1/0 are the link clock. Within each pair, the higher bit is the plus leg.
- R2: In every cycle, including during reset, each minus leg (bits 6, 4, 2, 0) is the inverse of the plus leg directly above it.
- R3: `symLoad` is high in exactly one cycle out of every ten, with nine low cycles between two highs. The first high is the first cycle after reset is released. The three symbols are captured at the clock edge that ends a cycle in which `symLoad` is high.
- R4: In the k-th cycle after a capture edge (k = 0..9), each colour plus leg shows bit k of the symbol that was captured. The bits therefore go out LSB first, and the next symbol follows with no gap.
- R5: In the same cycles k = 0..4 the clock plus leg is 1, and in cycles k = 5..9 it is 0.
- R6: `pixelIdx` and `lineIdx` give the position of the pixel being loaded. The pixel index counts 0..H_TOTAL-1 and steps by one on each capture edge. When it wraps, the line index steps by one, and the line index wraps to 0 after line V_ACTIVE+V_FRONT+V_SYNC+V_BACK-1. Both indices are stable between capture edges.
- R7: `lineKind` is 0 (visible) for lines below V_ACTIVE. It is 1 (blanking) for the next V_FRONT lines, 2 (blanking with vertical sync) for the V_SYNC lines after those, and 1 for the remaining back-porch lines. The value 3 never appears.
- R8: While reset is asserted, every plus leg is 0, so the output word is 8'h55, and `pixelIdx`, `lineIdx` and `lineKind` are all 0.
- R9: Symbol inputs in cycles where `symLoad` is low have no effect on the serial output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Asynchronous reset, active low |
| symRed | input | SYM_BITS (10) | Red channel symbol, captured on load |
| symGrn | input | SYM_BITS (10) | Green channel symbol, captured on load |
| symBlu | input | SYM_BITS (10) | Blue channel symbol, captured on load |
| symLoad | output | 1 | High in the cycle whose closing edge captures the symbols |
| pixelIdx | output | $clog2(H_TOTAL) (10) | Column of the pixel being loaded |
| lineIdx | output | $clog2(line total) (10) | Line of the pixel being loaded |
| lineKind | output | 2 | 0 visible, 1 blanking, 2 blanking with vertical sync |
| laneOut | output | 8 | {R+, R-, G+, G-, B+, B-, CLK+, CLK-} |

## Verification
Three events share one cycle: the capture of a new symbol triple, the last bit of the previous symbol, and the clock lane's return from low to high. On the final pixel of a line or of a frame, the pixel and line counters also wrap in that same cycle. The bench uses a reduced geometry so that it passes several frame wraps. It drives directed all-ones, all-zeros and alternating symbols, then random symbols. Between loads it changes the symbol inputs in every cycle. On every bit time it compares each lane with the bit that is expected from the symbol captured at the last load, and at each load it checks the raster position and the line kind.

// File: rtl/dvi_stream_pkg.sv
package dvi_stream_pkg;

  typedef enum logic [1:0] {
    KIND_VISIBLE = 2'd0,
    KIND_BLANK   = 2'd1,
    KIND_VSYNC   = 2'd2
  } lineKind_e;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;
  } strobe_t;

endpackage

// File: rtl/dvi_stream_lane.sv
module dvi_stream_lane #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [WIDTH-1:0] symIn,
  output logic             bitOut
);

  logic [WIDTH-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (load) begin
      shReg <= symIn;
    end else begin
      shReg <= {1'b0, shReg[WIDTH-1:1]};
    end
  end

  assign bitOut = shReg[0];

endmodule

// File: rtl/dvi_stream_datapath.sv
module dvi_stream_datapath
  import dvi_stream_pkg::*;
#(
  parameter int SYM_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [SYM_BITS-1:0] symRed,
  input  logic [SYM_BITS-1:0] symGrn,
  input  logic [SYM_BITS-1:0] symBlu,
  output logic [7:0]          laneOut
);

  localparam int LANES = 4;
  // Ones in the low half: high during the first half of each symbol period
  localparam logic [SYM_BITS-1:0] CLK_PAT = SYM_BITS'((1 << (SYM_BITS / 2)) - 1);

  // Lane 0 is the link clock, then blue, green, red, toward the MSB
  logic [LANES*SYM_BITS-1:0] laneSyms;
  logic [LANES-1:0]          plusBits;

  assign laneSyms = {symRed, symGrn, symBlu, CLK_PAT};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    dvi_stream_lane #(.WIDTH(SYM_BITS)) i_lane (
      .clk    (clk),
      .rstN   (rstN),
      .load   (strobe.load),
      .symIn  (laneSyms[k*SYM_BITS +: SYM_BITS]),
      .bitOut (plusBits[k])
    );
    assign laneOut[2*k+1] = plusBits[k];
    assign laneOut[2*k]   = ~plusBits[k];
  end

endmodule

// File: rtl/dvi_stream_ctrl.sv
module dvi_stream_ctrl
  import dvi_stream_pkg::*;
#(
  parameter int SYM_BITS = 10,
  parameter int H_TOTAL  = 800,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33,
  parameter int PIX_W    = $clog2(H_TOTAL),
  parameter int LINE_W   = $clog2(V_ACTIVE + V_FRONT + V_SYNC + V_BACK)
) (
  input  logic              clk,
  input  logic              rstN,
  output strobe_t           strobe,
  output logic [PIX_W-1:0]  pixelIdx,
  output logic [LINE_W-1:0] lineIdx,
  output lineKind_e         lineKind
);

  localparam int BIT_W   = $clog2(SYM_BITS);
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;

  localparam logic [BIT_W-1:0]  LAST_BIT   = BIT_W'(SYM_BITS - 1);
  localparam logic [PIX_W-1:0]  LAST_PIX   = PIX_W'(H_TOTAL - 1);
  localparam logic [LINE_W-1:0] LAST_LINE  = LINE_W'(V_TOTAL - 1);
  localparam logic [LINE_W-1:0] FRONT_BEG  = LINE_W'(V_ACTIVE);
  localparam logic [LINE_W-1:0] SYNC_BEG   = LINE_W'(V_ACTIVE + V_FRONT);
  localparam logic [LINE_W-1:0] SYNC_END   = LINE_W'(V_ACTIVE + V_FRONT + V_SYNC);

  logic [BIT_W-1:0] bitIdx;

  // Starts at the last bit so the first cycle out of reset is a load cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx <= LAST_BIT;
    end else if (bitIdx == LAST_BIT) begin
      bitIdx <= '0;
    end else begin
      bitIdx <= bitIdx + 1'b1;
    end
  end

  assign strobe.load = (bitIdx == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixelIdx <= '0;
      lineIdx  <= '0;
    end else if (strobe.load) begin
      if (pixelIdx == LAST_PIX) begin
        pixelIdx <= '0;
        lineIdx  <= (lineIdx == LAST_LINE) ? '0 : lineIdx + 1'b1;
      end else begin
        pixelIdx <= pixelIdx + 1'b1;
      end
    end
  end

  always_comb begin
    if (lineIdx < FRONT_BEG) begin
      lineKind = KIND_VISIBLE;
    end else if (lineIdx < SYNC_BEG) begin
      lineKind = KIND_BLANK;
    end else if (lineIdx < SYNC_END) begin
      lineKind = KIND_VSYNC;
    end else begin
      lineKind = KIND_BLANK;
    end
  end

endmodule

// File: rtl/dvi_line_serializer.sv
module dvi_line_serializer
  import dvi_stream_pkg::*;
#(
  parameter int SYM_BITS = 10,
  parameter int H_TOTAL  = 800,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33,
  localparam int PIX_W   = $clog2(H_TOTAL),
  localparam int LINE_W  = $clog2(V_ACTIVE + V_FRONT + V_SYNC + V_BACK)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SYM_BITS-1:0] symRed,
  input  logic [SYM_BITS-1:0] symGrn,
  input  logic [SYM_BITS-1:0] symBlu,
  output logic                symLoad,
  output logic [PIX_W-1:0]    pixelIdx,
  output logic [LINE_W-1:0]   lineIdx,
  output logic [1:0]          lineKind,
  output logic [7:0]          laneOut
);

  strobe_t   strobe;
  lineKind_e kindEnum;

  dvi_stream_ctrl #(
    .SYM_BITS (SYM_BITS),
    .H_TOTAL  (H_TOTAL),
    .V_ACTIVE (V_ACTIVE),
    .V_FRONT  (V_FRONT),
    .V_SYNC   (V_SYNC),
    .V_BACK   (V_BACK),
    .PIX_W    (PIX_W),
    .LINE_W   (LINE_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pixelIdx (pixelIdx),
    .lineIdx  (lineIdx),
    .lineKind (kindEnum)
  );

  dvi_stream_datapath #(.SYM_BITS(SYM_BITS)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .symRed  (symRed),
    .symGrn  (symGrn),
    .symBlu  (symBlu),
    .laneOut (laneOut)
  );

  assign symLoad  = strobe.load;
  assign lineKind = kindEnum;

endmodule

// File: rtl/dvi_line_serializer_chk.sv
module dvi_line_serializer_chk #(
  parameter int SYM_BITS = 10,
  parameter int H_TOTAL  = 800,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33,
  localparam int PIX_W   = $clog2(H_TOTAL),
  localparam int LINE_W  = $clog2(V_ACTIVE + V_FRONT + V_SYNC + V_BACK)
) (
  input logic                clk,
  input logic                rstN,
  input logic [SYM_BITS-1:0] symRed,
  input logic [SYM_BITS-1:0] symGrn,
  input logic [SYM_BITS-1:0] symBlu,
  input logic                symLoad,
  input logic [PIX_W-1:0]    pixelIdx,
  input logic [LINE_W-1:0]   lineIdx,
  input logic [1:0]          lineKind,
  input logic [7:0]          laneOut
);

  localparam int CW = $clog2(SYM_BITS) + 1;
  localparam logic [CW-1:0]     CNT_MAX  = '1;
  localparam logic [CW-1:0]     LAST_BIT = CW'(SYM_BITS - 1);
  localparam logic [CW-1:0]     SYM_LEN  = CW'(SYM_BITS);
  localparam logic [CW-1:0]     HALF     = CW'(SYM_BITS / 2);
  localparam logic [PIX_W-1:0]  LAST_PIX = PIX_W'(H_TOTAL - 1);
  localparam logic [LINE_W-1:0] SYNC_BEG = LINE_W'(V_ACTIVE + V_FRONT);
  localparam logic [LINE_W-1:0] SYNC_END = LINE_W'(V_ACTIVE + V_FRONT + V_SYNC);
  localparam logic [LINE_W-1:0] ACT_END  = LINE_W'(V_ACTIVE);

  logic [CW-1:0]       sinceLoad;
  logic                seenLoad;
  logic [SYM_BITS-1:0] capR, capG, capB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceLoad <= '0;
      seenLoad  <= 1'b0;
      capR      <= '0;
      capG      <= '0;
      capB      <= '0;
    end else if (symLoad) begin
      sinceLoad <= '0;
      seenLoad  <= 1'b1;
      capR      <= symRed;
      capG      <= symGrn;
      capB      <= symBlu;
    end else if (sinceLoad != CNT_MAX) begin
      sinceLoad <= sinceLoad + 1'b1;
    end
  end

  AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
    (laneOut[7] != laneOut[6]) && (laneOut[5] != laneOut[4]) &&
    (laneOut[3] != laneOut[2]) && (laneOut[1] != laneOut[0])); // R2

  AST_LOAD_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (seenLoad && symLoad) |-> (sinceLoad == LAST_BIT)); // R3

  AST_LOAD_NO_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (seenLoad && sinceLoad == LAST_BIT) |-> symLoad); // R3

  AST_LSB_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (seenLoad && sinceLoad < SYM_LEN) |->
      (laneOut[7] == capR[sinceLoad]) && (laneOut[5] == capG[sinceLoad]) &&
      (laneOut[3] == capB[sinceLoad])); // R4

  AST_CLOCK_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (seenLoad && sinceLoad < SYM_LEN) |-> (laneOut[1] == (sinceLoad < HALF))); // R5

  AST_PIXEL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (symLoad && pixelIdx != LAST_PIX) |=> (pixelIdx == $past(pixelIdx) + 1'b1)); // R6

  AST_POSITION_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !symLoad |=> ($stable(pixelIdx) && $stable(lineIdx) && $stable(lineKind))); // R6

  AST_KIND_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (lineIdx < ACT_END) |-> (lineKind == 2'd0)); // R7

  AST_KIND_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (lineIdx >= SYNC_BEG && lineIdx < SYNC_END) |-> (lineKind == 2'd2)); // R7

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    lineKind != 2'd3); // R7

endmodule

bind dvi_line_serializer dvi_line_serializer_chk #(
  .SYM_BITS (SYM_BITS),
  .H_TOTAL  (H_TOTAL),
  .V_ACTIVE (V_ACTIVE),
  .V_FRONT  (V_FRONT),
  .V_SYNC   (V_SYNC),
  .V_BACK   (V_BACK)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .symRed   (symRed),
  .symGrn   (symGrn),
  .symBlu   (symBlu),
  .symLoad  (symLoad),
  .pixelIdx (pixelIdx),
  .lineIdx  (lineIdx),
  .lineKind (lineKind),
  .laneOut  (laneOut)
);

// File: tb/test_dvi_line_serializer.sv
`timescale 1ns/1ps
module test_dvi_line_serializer;

  localparam int SB = 10;
  localparam int HT = 8;
  localparam int VA = 4;
  localparam int VF = 1;
  localparam int VS = 2;
  localparam int VB = 2;
  localparam int VT = VA + VF + VS + VB;
  localparam int PW = $clog2(HT);
  localparam int LW = $clog2(VT);
  localparam int NCYC = 2 * VT * HT * SB + 45;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [SB-1:0] symRed = '0, symGrn = '0, symBlu = '0;
  logic          symLoad;
  logic [PW-1:0] pixelIdx;
  logic [LW-1:0] lineIdx;
  logic [1:0]    lineKind;
  logic [7:0]    laneOut;

  int  checks = 0;
  int  fails = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  dvi_line_serializer #(
    .SYM_BITS(SB), .H_TOTAL(HT), .V_ACTIVE(VA),
    .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
  ) i_dvi_line_serializer (
    .clk(clk), .rstN(rstN), .symRed(symRed), .symGrn(symGrn), .symBlu(symBlu),
    .symLoad(symLoad), .pixelIdx(pixelIdx), .lineIdx(lineIdx),
    .lineKind(lineKind), .laneOut(laneOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int kindOf(input int line);
    if (line < VA) return 0;
    if (line < VA + VF) return 1;
    if (line < VA + VF + VS) return 2;
    return 1;
  endfunction

  function automatic bit pairsOk(input logic [7:0] w);
    return (w[6] == ~w[7]) && (w[4] == ~w[5]) && (w[2] == ~w[3]) && (w[0] == ~w[1]);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [SB-1:0] expR, expG, expB;
    logic [SB-1:0] dirR [4];
    logic [SB-1:0] dirG [4];
    logic [SB-1:0] dirB [4];
    void'($urandom(32'd7321));
    dirR[0] = 10'h3FF; dirG[0] = 10'h000; dirB[0] = 10'h155;
    dirR[1] = 10'h000; dirG[1] = 10'h3FF; dirB[1] = 10'h2AA;
    dirR[2] = 10'h201; dirG[2] = 10'h1FE; dirB[2] = 10'h3C0;
    dirR[3] = 10'h2AA; dirG[3] = 10'h155; dirB[3] = 10'h01F;
    expR = '0; expG = '0; expB = '0;

    // R8: reset state, with symbols changing while reset is held
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      symRed = SB'($urandom); symGrn = SB'($urandom); symBlu = SB'($urandom);
      check(laneOut == 8'h55, "R8 lanes in reset", laneOut, 8'h55);
    end
    check(pixelIdx == 0, "R8 pixelIdx in reset", pixelIdx, 0);
    check(lineIdx == 0, "R8 lineIdx in reset", lineIdx, 0);
    check(lineKind == 0, "R8 lineKind in reset", lineKind, 0);
    check(pairsOk(laneOut), "R2 pairs in reset", laneOut, 8'h55);

    @(negedge clk);
    rstN = 1'b1;

    for (int n = 0; n < NCYC; n++) begin
      int k;
      k = (n + SB - 1) % SB;
      check(symLoad == (n % SB == 0), "R3 load cadence", symLoad, (n % SB == 0));
      check(pairsOk(laneOut), "R2 complement legs", laneOut, 0);
      if (n >= 1) begin
        // R1 lane positions, R4 LSB-first order, R9 ignored inputs
        check(laneOut[7] == expR[k], "R1 R4 R9 red bit", laneOut[7], expR[k]);
        check(laneOut[5] == expG[k], "R1 R4 R9 green bit", laneOut[5], expG[k]);
        check(laneOut[3] == expB[k], "R1 R4 R9 blue bit", laneOut[3], expB[k]);
        check(laneOut[1] == (k < SB / 2), "R1 R5 clock leg", laneOut[1], (k < SB / 2));
      end else begin
        check(laneOut == 8'h55, "R8 lanes before first symbol", laneOut, 8'h55);
      end
      if (n % SB == 0) begin
        int p;
        p = n / SB;
        check(pixelIdx == PW'(p % HT), "R6 pixel index", pixelIdx, p % HT);
        check(lineIdx == LW'((p / HT) % VT), "R6 line index", lineIdx, (p / HT) % VT);
        check(int'(lineKind) == kindOf((p / HT) % VT), "R7 line kind", lineKind,
              kindOf((p / HT) % VT));
        if (p < 4) begin
          symRed = dirR[p]; symGrn = dirG[p]; symBlu = dirB[p];
        end else begin
          symRed = SB'($urandom); symGrn = SB'($urandom); symBlu = SB'($urandom);
        end
        expR = symRed; expG = symGrn; expB = symBlu;
      end else begin
        // R9: scramble inputs outside load cycles
        symRed = SB'($urandom); symGrn = SB'($urandom); symBlu = SB'($urandom);
      end
      @(negedge clk);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule